// File: doc/BRIEF.md
# Level-Sensitive Interrupt Router

This block gathers 32 level-sensitive interrupt lines and presents them to a processor on two interrupt outputs. A single enable mask decides which lines may be seen at all. The topmost mask bit does not guard a line. It is a master switch that gates both outputs. A route word then sends each enabled line to output 0 or to output 1.

Software reaches the block through a single-cycle register port. Two write-only views act on the mask: one sets the mask bits that are written as 1, and the other clears them. Bits written as 0 leave the mask unchanged, so separate handlers can change their own lines without a read-modify-write. Software can read the raw line levels and a pending word for each output. Lines are level-sensitive and there is no acknowledge register: a pending bit disappears only when its line drops or its mask bit is cleared. As a convenience, the block also reports the number of the lowest pending line on output 0.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the mask and route words are zero, both interrupt outputs are low, the lowest-index valid flag is low and read data is zero.
- R2: A write to offset 0x34 sets every mask bit that is 1 in the write data. Mask bits written as 0 keep their value.
- R3: A write to offset 0x38 clears every mask bit that is 1 in the write data. Writing all ones clears the whole mask.
- R4: Mask bit 31 is the master enable. While it is 0, both interrupt outputs stay low, whatever the lines and the route word hold.
- R5: Route bit i at 0 sends line i to the output-0 pending word (offset 0x00). Route bit i at 1 sends it to the output-1 pending word (offset 0x04). Pending word n is raw AND mask AND the route selection for n, with bit 31 always 0. The route word is written and read at offset 0x20.
- R6: A read of offset 0x30 returns the unmasked levels of all 32 lines.
- R7: Pending state is level-sensitive. When a line drops, its effect on an interrupt output is gone one clock later, and no acknowledge write is needed.
- R8: Interrupt output n is registered. It equals the OR of pending word n, ANDed with mask bit 31, as that value stood one clock earlier.
- R9: The lowest-index output is registered. It gives the number of the lowest set bit of the output-0 pending word, and its valid flag is set when that word is non-zero. When the word is zero, the index is 0 and the flag is low.
- R10: Read data is registered and appears the cycle after the read strobe. It is zero when no read strobe was given. Reads of offset 0x34 or 0x38 return the current mask. Reads of unmapped offsets return zero.
- R11: Line 9, the performance-counter line, can be routed to either output like any other line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Level-sensitive interrupt lines |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| irq0_o | output | 1 | Interrupt output 0 |
| irq1_o | output | 1 | Interrupt output 1 |
| lowest_idx_o | output | 5 | Lowest pending line on output 0 |
| lowest_vld_o | output | 1 | Output-0 pending word non-zero |

## Verification
The bench builds the block with the package defaults: 32 lines and an 8-bit offset. At that width the master-enable bit coincides with a real line, line 31, so the exclusion of that line from both pending words can be tested. The route word can split a single line set across both outputs at once. The index search runs across the full width, from bit 0 up to bit 30.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    localparam int SRC_N   = 32;
    localparam int ADDR_W  = 8;
    localparam int IDX_W   = $clog2(SRC_N);
    localparam int OUT_N   = 2;
    localparam int GLB_BIT = SRC_N - 1;

    localparam logic [ADDR_W-1:0] OFS_PEND0 = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PEND1 = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ROUTE = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_SET   = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h38;

    typedef enum logic [2:0] {
        SEL_PEND0, SEL_PEND1, SEL_ROUTE, SEL_RAW, SEL_SET, SEL_CLR, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [SRC_N-1:0] mask;
        logic [SRC_N-1:0] route;
    } ctl_state_t;

    function automatic reg_sel_e decode_ofs(logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_PEND0: s = SEL_PEND0;
            OFS_PEND1: s = SEL_PEND1;
            OFS_ROUTE: s = SEL_ROUTE;
            OFS_RAW:   s = SEL_RAW;
            OFS_SET:   s = SEL_SET;
            OFS_CLR:   s = SEL_CLR;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [IDX_W-1:0] lowest_set(logic [SRC_N-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (v[i]) r = i[IDX_W-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import lvl_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  reg_sel_e         sel,
    input  logic [SRC_N-1:0] wdata,
    output ctl_state_t       st_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (we) begin
            case (sel)
                SEL_SET:   st_q.mask  <= st_q.mask | wdata;
                SEL_CLR:   st_q.mask  <= st_q.mask & ~wdata;
                SEL_ROUTE: st_q.route <= wdata;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/irq_ctl_route.sv
module irq_ctl_route
    import lvl_irq_pkg::*;
(
    input  logic             [SRC_N-1:0] src,
    input  ctl_state_t                   st,
    output logic [OUT_N-1:0] [SRC_N-1:0] pend
);
    localparam logic [SRC_N-1:0] LINE_BITS = ~(SRC_N'(1) << GLB_BIT);

    for (genvar o = 0; o < OUT_N; o++) begin : g_out
        logic [SRC_N-1:0] sel_w;
        assign sel_w   = (o == 0) ? ~st.route : st.route;
        assign pend[o] = src & st.mask & sel_w & LINE_BITS;
    end
endmodule

// File: rtl/irq_ctl_outreg.sv
module irq_ctl_outreg
    import lvl_irq_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [OUT_N-1:0] [SRC_N-1:0] pend,
    input  logic                         glb_en,
    output logic             [OUT_N-1:0] irq_q,
    output logic             [IDX_W-1:0] idx_q,
    output logic                         vld_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            idx_q <= '0;
            vld_q <= 1'b0;
        end else begin
            for (int o = 0; o < OUT_N; o++) begin
                irq_q[o] <= (|pend[o]) & glb_en;
            end
            idx_q <= lowest_set(pend[0]);
            vld_q <= |pend[0];
        end
    end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  src_i,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [SRC_N-1:0]  reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [SRC_N-1:0]  reg_rdata,
    output logic              irq0_o,
    output logic              irq1_o,
    output logic [IDX_W-1:0]  lowest_idx_o,
    output logic              lowest_vld_o
);
    reg_sel_e                     sel;
    ctl_state_t                   st_q;
    logic [OUT_N-1:0] [SRC_N-1:0] pend;
    logic [OUT_N-1:0]             irq_q;
    logic [SRC_N-1:0]             mask_q;
    logic [SRC_N-1:0]             route_q;
    logic [SRC_N-1:0]             rd_mux;

    assign sel     = decode_ofs(reg_addr);
    assign mask_q  = st_q.mask;
    assign route_q = st_q.route;

    irq_ctl_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .sel   (sel),
        .wdata (reg_wdata),
        .st_q  (st_q)
    );

    irq_ctl_route u_route (
        .src  (src_i),
        .st   (st_q),
        .pend (pend)
    );

    irq_ctl_outreg u_out (
        .clk    (clk),
        .rst    (rst),
        .pend   (pend),
        .glb_en (mask_q[GLB_BIT]),
        .irq_q  (irq_q),
        .idx_q  (lowest_idx_o),
        .vld_q  (lowest_vld_o)
    );

    assign irq0_o = irq_q[0];
    assign irq1_o = irq_q[1];

    always_comb begin
        case (sel)
            SEL_PEND0:       rd_mux = pend[0];
            SEL_PEND1:       rd_mux = pend[1];
            SEL_ROUTE:       rd_mux = route_q;
            SEL_RAW:         rd_mux = src_i;
            SEL_SET, SEL_CLR: rd_mux = mask_q;
            default:         rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !reg_re) reg_rdata <= '0;
        else                reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk
    import lvl_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [SRC_N-1:0]  src_i,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [SRC_N-1:0]  reg_wdata,
    input logic              reg_we,
    input logic [SRC_N-1:0]  mask_q,
    input logic [SRC_N-1:0]  route_q,
    input logic              irq0_o,
    input logic              irq1_o,
    input logic              lowest_vld_o
);
    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFS_SET) |=> ((mask_q & $past(reg_wdata)) == $past(reg_wdata)));

    p_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFS_CLR) |=> ((mask_q & $past(reg_wdata)) == '0));

    p_gate_r4: assert property (@(posedge clk) disable iff (rst)
        !mask_q[GLB_BIT] |=> (!irq0_o && !irq1_o));

    p_route1_r5: assert property (@(posedge clk) disable iff (rst)
        irq1_o |-> $past(|(src_i & mask_q & route_q)));

    p_route0_r8: assert property (@(posedge clk) disable iff (rst)
        irq0_o |-> $past(|(src_i & mask_q & ~route_q)));

    p_lowest_r9: assert property (@(posedge clk) disable iff (rst)
        (lowest_vld_o && $past(mask_q[GLB_BIT])) |-> irq0_o);
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .src_i        (src_i),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_we       (reg_we),
    .mask_q       (mask_q),
    .route_q      (route_q),
    .irq0_o       (irq0_o),
    .irq1_o       (irq1_o),
    .lowest_vld_o (lowest_vld_o)
);

// File: tb/test_lvl_irq_ctrl.sv
module test_lvl_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_i = '0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq0_o, irq1_o, lowest_vld_o;
    logic [4:0]  lowest_idx_o;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lvl_irq_ctrl i_lvl_irq_ctrl (
        .clk(clk), .rst(rst), .src_i(src_i), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata), .irq0_o(irq0_o), .irq1_o(irq1_o),
        .lowest_idx_o(lowest_idx_o), .lowest_vld_o(lowest_vld_o)
    );

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] msk;
        logic [31:0] rte;
        logic [31:0] e0;
        logic [31:0] e1;
        logic        q0;
        logic        q1;
        logic [4:0]  idx;
        logic        vld;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h0000_0210, 32'h8000_0210, 32'h0000_0000, 32'h0000_0210, 32'h0000_0000, 1'b1, 1'b0, 5'd4,  1'b1},
        '{32'h0000_0200, 32'h8000_0200, 32'h0000_0200, 32'h0000_0000, 32'h0000_0200, 1'b0, 1'b1, 5'd0,  1'b0},
        '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_FF00, 32'h0000_00FF, 32'h0000_FF00, 1'b0, 1'b0, 5'd0,  1'b1},
        '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 5'd0,  1'b0},
        '{32'h4000_0001, 32'hC000_0000, 32'h0000_0000, 32'h4000_0000, 32'h0000_0000, 1'b1, 1'b0, 5'd30, 1'b1},
        '{32'h0F0F_0F00, 32'h8F00_FF00, 32'h0F00_0000, 32'h0000_0F00, 32'h0F00_0000, 1'b1, 1'b1, 5'd8,  1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 irq0", {31'd0, irq0_o}, 32'd0);
        check("R1 irq1", {31'd0, irq1_o}, 32'd0);
        check("R1 vld", {31'd0, lowest_vld_o}, 32'd0);
        check("R1 rdata", reg_rdata, 32'd0);
        rd(8'h34, rv); check("R1 mask", rv, 32'd0);
        rd(8'h20, rv); check("R1 route", rv, 32'd0);

        // vector table: R5 R6 R8 R9 R11
        for (int k = 0; k < 6; k++) begin
            wr(8'h38, 32'hFFFF_FFFF);
            wr(8'h34, VECS[k].msk);
            wr(8'h20, VECS[k].rte);
            @(negedge clk); src_i = VECS[k].src;
            settle();
            check("R8 irq0", {31'd0, irq0_o}, {31'd0, VECS[k].q0});
            check("R8 irq1", {31'd0, irq1_o}, {31'd0, VECS[k].q1});
            check("R9 idx", {27'd0, lowest_idx_o}, {27'd0, VECS[k].idx});
            check("R9 vld", {31'd0, lowest_vld_o}, {31'd0, VECS[k].vld});
            rd(8'h00, rv); check("R5 pend0", rv, VECS[k].e0);
            rd(8'h04, rv); check("R5 pend1", rv, VECS[k].e1);
            rd(8'h30, rv); check("R6 raw", rv, VECS[k].src);
            rd(8'h34, rv); check("R10 mask read", rv, VECS[k].msk);
            rd(8'h20, rv); check("R5 route read", rv, VECS[k].rte);
        end
        // R11: line 9 went to output 0 in vector 0 and to output 1 in vector 1

        // R3 all ones clears the mask
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h38, rv); check("R3 clear all", rv, 32'd0);

        // R2 set accumulates, zeros keep
        wr(8'h34, 32'h0000_0001);
        wr(8'h34, 32'h0000_0004);
        rd(8'h34, rv); check("R2 accumulate", rv, 32'h0000_0005);

        // R3 partial clear
        wr(8'h38, 32'h0000_0001);
        rd(8'h38, rv); check("R3 partial", rv, 32'h0000_0004);

        // R4 master enable gates outputs
        wr(8'h20, 32'h0000_0000);
        @(negedge clk); src_i = 32'h0000_0004;
        settle();
        check("R4 gated", {30'd0, irq1_o, irq0_o}, 32'd0);
        wr(8'h34, 32'h8000_0000);
        settle();
        check("R4 enabled", {31'd0, irq0_o}, 32'd1);
        wr(8'h38, 32'h8000_0000);
        settle();
        check("R4 disabled again", {31'd0, irq0_o}, 32'd0);

        // R7 level behaviour without acknowledge
        wr(8'h34, 32'h8000_0000);
        settle();
        check("R7 asserted", {31'd0, irq0_o}, 32'd1);
        src_i = 32'h0;
        @(negedge clk);
        check("R7 line dropped", {31'd0, irq0_o}, 32'd0);
        src_i = 32'h0000_0004;
        @(negedge clk);
        check("R7 line back", {31'd0, irq0_o}, 32'd1);

        // R10 unmapped read and no strobe
        rd(8'h10, rv); check("R10 unmapped", rv, 32'd0);
        @(negedge clk);
        check("R10 no strobe", reg_rdata, 32'd0);

        // R1 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 irq after reset", {31'd0, irq0_o}, 32'd0);
        rd(8'h34, rv); check("R1 mask after reset", rv, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule